// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a shared memory and decides, for every store, whether the write may go ahead. Requesters are identified by a CPU number and a thread number. A load-linked request records a reservation for the 16-byte granule that holds its address, tagged with the requesting context. Every store is compared against all held reservations, whether it is conditional or not. A plain store always writes and removes every reservation on its granule. A store-conditional writes only when its own context still holds a reservation on that granule.

Each request is captured in a register. The verdict is formed combinationally from that register and the reservation table, so the response appears in the cycle after the request. The table changes at the clock edge that ends the response cycle. The table has a parameterised number of entries. Each context holds at most one entry. When the table is full, a round-robin pointer chooses which entry is evicted.

Top module: `llsc_monitor`

## Requirements
- R1: Addresses are compared at 16-byte granularity: addresses that differ only in bits [3:0] hit the same reservation, and addresses in different granules never do.
- R2: After a load-linked (op 2'b01) from a context, a store-conditional (op 2'b11) from the same context to the same granule responds with write-enable 1 and SC result 1.
- R3: A reservation belongs to a requester only when both the CPU number and the thread number are equal. A store-conditional from a context differing in either one fails with write-enable 0 and result 0.
- R4: When the table holds no reservations, a store-conditional is suppressed: write-enable 0, result 0.
- R5: A plain store (op 2'b10) always responds with write-enable 1 and result 0.
- R6: A plain store clears every reservation, of any context, on its granule. Later store-conditionals to that granule fail.
- R7: A successful store-conditional clears every reservation on its granule, including those of other contexts.
- R8: A failed store-conditional changes no reservation, neither its own context's entry for another granule nor other contexts' entries.
- R9: A load-linked from a context that already holds a reservation replaces it. The old granule is no longer reserved for that context, and no extra table entry is used.
- R10: A load-linked from a new context goes to the lowest free entry. When no entry is free, the entry at the round-robin pointer is evicted and the pointer advances by one, wrapping after the last entry.
- R11: The response is valid exactly one cycle after the request. A plain load (op 2'b00) and a load-linked respond with write-enable 0 and result 0, and without a request the response is not valid.
- R12: Reset invalidates all reservations and the response valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | 00 load, 01 load-linked, 10 store, 11 store-conditional |
| req_addr_i | input | ADDR_W | Byte address |
| req_cpu_i | input | CPU_W | Requesting CPU number |
| req_thr_i | input | THR_W | Requesting thread number |
| rsp_valid_o | output | 1 | Response for the request of the previous cycle |
| rsp_wr_en_o | output | 1 | Store may write memory |
| rsp_sc_ok_o | output | 1 | Store-conditional result (1 success, 0 failure) |

## Verification
The hardest state to reach is a full table whose round-robin pointer has already moved. Only load-linked requests from as many distinct contexts as there are entries fill the table, and only further new contexts force evictions. The bench fills all four entries with four contexts, then adds two more contexts so that two evictions happen in a row. It then probes every one of the six contexts with a store-conditional. The two evicted contexts must fail and the other four must succeed.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_LL   = 2'b01,
    OP_ST   = 2'b10,
    OP_SC   = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_entry_match.sv
module llsc_entry_match #(
  parameter int TAG_W = 28,
  parameter int CPU_W = 2,
  parameter int THR_W = 2
) (
  input  logic             valid_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  logic [CPU_W-1:0] ent_cpu_i,
  input  logic [THR_W-1:0] ent_thr_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic [CPU_W-1:0] req_cpu_i,
  input  logic [THR_W-1:0] req_thr_i,
  output logic             ctx_hit_o,
  output logic             gran_hit_o
);
  assign ctx_hit_o  = valid_i && (ent_cpu_i == req_cpu_i) && (ent_thr_i == req_thr_i);
  assign gran_hit_o = valid_i && (ent_tag_i == req_tag_i);
endmodule

// File: rtl/llsc_victim_sel.sv
module llsc_victim_sel #(
  parameter int NUM_ENT = 4,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ENT-1:0] valid_i,
  input  logic [NUM_ENT-1:0] ctx_hit_i,
  input  logic               alloc_i,
  output logic [IDX_W-1:0]   victim_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] ctx_idx, free_idx;
  logic             ctx_any, free_any;

  always_comb begin
    ctx_idx  = '0;
    free_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (ctx_hit_i[i]) ctx_idx = IDX_W'(i);
      if (!valid_i[i])  free_idx = IDX_W'(i);
    end
    ctx_any  = |ctx_hit_i;
    free_any = ~&valid_i;
    victim_o = ctx_any ? ctx_idx : (free_any ? free_idx : rr_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (alloc_i && !ctx_any && !free_any)
      rr_q <= (rr_q == IDX_W'(NUM_ENT - 1)) ? '0 : rr_q + 1'b1;
  end

  p_rr_in_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_q <= IDX_W'(NUM_ENT - 1));
  // R10: eviction only when the table is full and the context is new
  p_evict_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !ctx_any && free_any) |=> $stable(rr_q));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CPU_W   = 2,
  parameter int THR_W   = 2,
  parameter int GRAN_W  = 4,
  parameter int NUM_ENT = 4,
  localparam int TAG_W = ADDR_W - GRAN_W,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CPU_W-1:0]  req_cpu_i,
  input  logic [THR_W-1:0]  req_thr_i,
  output logic              rsp_valid_o,
  output logic              rsp_wr_en_o,
  output logic              rsp_sc_ok_o
);
  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    logic [CPU_W-1:0] cpu;
    logic [THR_W-1:0] thr;
  } ent_t;

  logic             rq_vld;
  llsc_op_e         rq_op;
  logic [TAG_W-1:0] rq_tag;
  logic [CPU_W-1:0] rq_cpu;
  logic [THR_W-1:0] rq_thr;

  ent_t             tbl_q [NUM_ENT];
  logic [NUM_ENT-1:0] vld_vec, ctx_hit, gran_hit;
  logic [IDX_W-1:0] victim;
  logic             sc_ok, do_ll, do_clr;

  // request register: granule tag drops the low address bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_vld <= 1'b0;
      rq_op  <= OP_LOAD;
      rq_tag <= '0;
      rq_cpu <= '0;
      rq_thr <= '0;
    end else begin
      rq_vld <= req_valid_i;
      if (req_valid_i) begin
        rq_op  <= llsc_op_e'(req_op_i);
        rq_tag <= req_addr_i[ADDR_W-1:GRAN_W];
        rq_cpu <= req_cpu_i;
        rq_thr <= req_thr_i;
      end
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    assign vld_vec[g] = tbl_q[g].vld;
    llsc_entry_match #(.TAG_W(TAG_W), .CPU_W(CPU_W), .THR_W(THR_W)) u_match (
      .valid_i   (tbl_q[g].vld),
      .ent_tag_i (tbl_q[g].tag),
      .ent_cpu_i (tbl_q[g].cpu),
      .ent_thr_i (tbl_q[g].thr),
      .req_tag_i (rq_tag),
      .req_cpu_i (rq_cpu),
      .req_thr_i (rq_thr),
      .ctx_hit_o (ctx_hit[g]),
      .gran_hit_o(gran_hit[g])
    );
  end

  assign do_ll = rq_vld && (rq_op == OP_LL);

  llsc_victim_sel #(.NUM_ENT(NUM_ENT)) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (vld_vec),
    .ctx_hit_i(ctx_hit),
    .alloc_i  (do_ll),
    .victim_o (victim)
  );

  assign sc_ok  = rq_vld && (rq_op == OP_SC) && |(ctx_hit & gran_hit);
  assign do_clr = (rq_vld && (rq_op == OP_ST)) || sc_ok;

  assign rsp_valid_o = rq_vld;
  assign rsp_sc_ok_o = sc_ok;
  assign rsp_wr_en_o = (rq_vld && (rq_op == OP_ST)) || sc_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ENT; i++) tbl_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (do_ll && (victim == IDX_W'(i)))
          tbl_q[i] <= '{vld: 1'b1, tag: rq_tag, cpu: rq_cpu, thr: rq_thr};
        else if (do_clr && gran_hit[i])
          tbl_q[i].vld <= 1'b0;
      end
    end
  end

  p_sc_ok_writes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_sc_ok_o |-> (rsp_wr_en_o && rsp_valid_o));
  p_sc_empty_fails_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rq_vld && rq_op == OP_SC && vld_vec == '0) |-> (!rsp_wr_en_o && !rsp_sc_ok_o));
  p_store_writes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rq_vld && rq_op == OP_ST) |-> (rsp_wr_en_o && !rsp_sc_ok_o));
  p_store_no_grow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rq_vld && rq_op == OP_ST) |=> ($countones(vld_vec) <= $past($countones(vld_vec))));
  p_sc_fail_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rq_vld && rq_op == OP_SC && !rsp_sc_ok_o) |=> $stable(vld_vec));
  p_ctx_unique_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctx_hit));
  p_ll_no_resp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rq_vld && (rq_op == OP_LL || rq_op == OP_LOAD)) |-> (!rsp_wr_en_o && !rsp_sc_ok_o));
  p_ll_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_ll |=> (vld_vec != '0));
endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_op = 2'b00;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_cpu = '0;
  logic [1:0]        req_thr = '0;
  logic              rsp_valid, rsp_wr_en, rsp_sc_ok;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [1:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  llsc_monitor dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_cpu_i(req_cpu), .req_thr_i(req_thr),
    .rsp_valid_o(rsp_valid), .rsp_wr_en_o(rsp_wr_en), .rsp_sc_ok_o(rsp_sc_ok)
  );

  // monitor: pop and compare at every negedge
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected response got wr=%0b ok=%0b expected none", rsp_wr_en, rsp_sc_ok);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_wr_en, rsp_sc_ok} !== e) begin
          fails++;
          $display("FAIL %s got wr=%0b ok=%0b expected wr=%0b ok=%0b",
                   t, rsp_wr_en, rsp_sc_ok, e[1], e[0]);
        end
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [1:0] c,
                       input logic [1:0] t, input logic ew, input logic eo, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_cpu = c; req_thr = t;
    exp_q.push_back({ew, eo});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic check_no_rsp(input string tag);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL %s rsp_valid got %0b expected 0", tag, rsp_valid);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_no_rsp("R12 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_no_rsp("R11 idle");
    // R4 / R5 / R11: empty table
    issue(2'b11, 32'h100, 0, 0, 0, 0, "R4 sc on empty table");
    issue(2'b10, 32'h100, 0, 0, 1, 0, "R5 plain store");
    issue(2'b00, 32'h100, 0, 0, 0, 0, "R11 plain load");
    // R2 / R1
    issue(2'b01, 32'h204, 0, 0, 0, 0, "R11 ll response");
    issue(2'b11, 32'h20C, 0, 0, 1, 1, "R1 R2 sc same granule");
    issue(2'b11, 32'h204, 0, 0, 0, 0, "R7 sc after own success");
    // R3
    issue(2'b01, 32'h300, 1, 2, 0, 0, "R11 ll");
    issue(2'b11, 32'h300, 1, 3, 0, 0, "R3 thread differs");
    issue(2'b11, 32'h300, 2, 2, 0, 0, "R3 cpu differs");
    issue(2'b11, 32'h300, 1, 2, 1, 1, "R3 R8 owner succeeds");
    // R7
    issue(2'b01, 32'h400, 0, 1, 0, 0, "R11 ll");
    issue(2'b01, 32'h408, 1, 1, 0, 0, "R11 ll");
    issue(2'b11, 32'h404, 1, 1, 1, 1, "R7 first sc");
    issue(2'b11, 32'h400, 0, 1, 0, 0, "R7 other ctx cleared");
    // R6
    issue(2'b01, 32'h500, 2, 0, 0, 0, "R11 ll");
    issue(2'b01, 32'h500, 3, 0, 0, 0, "R11 ll");
    issue(2'b10, 32'h50F, 0, 0, 1, 0, "R5 R6 store to granule");
    issue(2'b11, 32'h500, 2, 0, 0, 0, "R6 cleared ctx a");
    issue(2'b11, 32'h500, 3, 0, 0, 0, "R6 cleared ctx b");
    // R1 negative
    issue(2'b01, 32'h600, 0, 0, 0, 0, "R11 ll");
    issue(2'b11, 32'h610, 0, 0, 0, 0, "R1 next granule fails");
    issue(2'b11, 32'h600, 0, 0, 1, 1, "R1 R8 own kept");
    // R8
    issue(2'b01, 32'hA00, 0, 0, 0, 0, "R11 ll");
    issue(2'b01, 32'hA10, 1, 0, 0, 0, "R11 ll");
    issue(2'b11, 32'hA10, 0, 0, 0, 0, "R8 wrong granule for ctx");
    issue(2'b11, 32'hA10, 1, 0, 1, 1, "R8 other ctx kept");
    issue(2'b11, 32'hA00, 0, 0, 1, 1, "R8 own entry kept");
    // R9
    issue(2'b01, 32'h700, 1, 1, 0, 0, "R11 ll");
    issue(2'b01, 32'h710, 1, 1, 0, 0, "R11 ll replace");
    issue(2'b11, 32'h700, 1, 1, 0, 0, "R9 old granule dropped");
    issue(2'b11, 32'h710, 1, 1, 1, 1, "R9 new granule held");
    // R10: fill four, then two evictions
    issue(2'b01, 32'h800, 0, 0, 0, 0, "R11 ll");
    issue(2'b01, 32'h810, 0, 1, 0, 0, "R11 ll");
    issue(2'b01, 32'h820, 1, 0, 0, 0, "R11 ll");
    issue(2'b01, 32'h830, 1, 1, 0, 0, "R11 ll");
    issue(2'b01, 32'h840, 2, 0, 0, 0, "R11 ll evict");
    issue(2'b01, 32'h850, 2, 1, 0, 0, "R11 ll evict");
    issue(2'b11, 32'h800, 0, 0, 0, 0, "R10 entry0 evicted");
    issue(2'b11, 32'h810, 0, 1, 0, 0, "R10 entry1 evicted");
    issue(2'b11, 32'h820, 1, 0, 1, 1, "R10 entry2 kept");
    issue(2'b11, 32'h830, 1, 1, 1, 1, "R10 entry3 kept");
    issue(2'b11, 32'h840, 2, 0, 1, 1, "R10 new ctx e");
    issue(2'b11, 32'h850, 2, 1, 1, 1, "R10 new ctx f");
    // R12: reset mid-run
    issue(2'b01, 32'h900, 3, 3, 0, 0, "R11 ll");
    idle(3);
    rst_n = 1'b0;
    @(negedge clk);
    check_no_rsp("R12 reset drops response");
    rst_n = 1'b1;
    issue(2'b11, 32'h900, 3, 3, 0, 0, "R12 reservation gone");
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11 missing responses got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule